// File: doc/BRIEF.md
# Tightly Coupled Memory Write-Merge Controller

This block sits between a 32-bit processor store path and a tightly coupled memory port that is always written 64 bits at a time. The memory side computes its own error code when it writes. A store that covers all eight bytes of a word goes straight to the memory. A narrower store is turned into a read of the enclosing word, a byte merge, and a full-word write. A store-multiple of several 32-bit registers is packed into 64-bit beats. An odd trailing register takes the read-modify-write path.

Every internal read is checked in the same way as a processor load. A memory-side bus error is taken into account only when the external-error enable is set. A mismatch of the SECDED check byte is taken into account only when the check enable is set. If either one fires, the request ends with an abort and a fault status code, and no write follows the failed read. Writes are never checked for errors, so a full-width store cannot abort. The processor side uses a ready/valid handshake and is stalled until the current request has finished. The end of each request is marked by a one-cycle completion pulse.

Top module: `tcm_merge_ctrl`

## Requirements
- R1: A store with all eight strobes set issues one write of reqData[63:0] to word reqAddr>>3 in the cycle after acceptance, with no read. Its completion pulse follows one cycle later, and it never aborts, even when the word is unimplemented.
- R2: A store with any strobe clear issues a read of word reqAddr>>3 in the cycle after acceptance. The read data returns in the cycle after that. The write of the merged word follows in the next cycle: byte b comes from reqData when reqStrb[b] is 1 and from the read data otherwise. The completion pulse comes one cycle after the write.
- R3: The rmwEn input has no effect on the sequence or on the data written. A narrow store always reads first.
- R4: A store-multiple (reqOp=2) with an even count n writes n/2 consecutive words starting at reqAddr>>3, one per cycle, with no read. Beat k carries register 2k in bits 31:0 and register 2k+1 in bits 63:32, where register i is reqData[32i+31:32i].
- R5: A store-multiple with an odd count first writes its pairs as in R4. The last register is then merged into bits 31:0 of the next word through the read-modify-write sequence of R2.
- R6: A load (reqOp=0) reads word reqAddr>>3 in the cycle after acceptance. It completes two cycles later, and doneData equals the read data.
- R7: In the read-response cycle, memErr causes an abort only when extErrEn is 1. A check-byte mismatch causes an abort only when eccEn is 1. With both enables clear there is no abort. An aborted read-modify-write issues no write.
- R8: The fault code is 0xC09 when the check error fires, including when a bus error fires with it. It is 0x008 for a bus error alone and 0x000 when there is no abort.
- R9: memErr outside a read-response cycle is ignored.
- R10: reqReady is high only while idle. It stays low from acceptance through the single-cycle doneValid pulse. The idle state shows no memory request.
- R11: The check byte follows the extended Hamming code over positions 1..71 with power-of-two positions left out. Data bit i takes the i-th remaining position. Check bit k (k<7) is the XOR of the data bits whose position has bit k set. Check bit 7 is the XOR of all 64 data bits and check bits 0..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Controller idle, request accepted when valid |
| reqOp | input | 2 | 0 load, 1 store, 2 store-multiple |
| reqAddr | input | AW | Byte address (store-multiple 8-byte aligned) |
| reqStrb | input | 8 | Byte enables for a single store |
| reqCount | input | CW | Register count of a store-multiple |
| reqData | input | 32*MAX_REGS | Store data or registers, register 0 lowest |
| rmwEn | input | 1 | Optional read-modify-write control, no effect |
| eccEn | input | 1 | Check-byte error enable |
| extErrEn | input | 1 | External bus-error enable |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW-3 | Word address |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, cycle after the read |
| memRcheck | input | 8 | Stored check byte with memRdata |
| memErr | input | 1 | Bus error with the read response |
| doneValid | output | 1 | Request complete |
| doneData | output | 64 | Load data |
| doneAbort | output | 1 | Request aborted |
| doneFault | output | 12 | Fault status code |

## Verification
A wrong sequencer state shows up at the ports as a memory request missing, added or moved by a cycle. It can also show as a write that follows a failed read, or as reqReady rising early. Because the reference model compares memReq, memWe, memAddr and reqReady on every cycle, such a fault is seen in the cycle it occurs. A stale beat index or word address shows up as a wrong write word or address on the next beat. A wrongly latched fault or merge register shows up at the single completion pulse or the following write, one or two cycles after the read returns.

// File: rtl/tcm_merge_pkg.sv
package tcm_merge_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_STM   = 2'd2,
    OP_RSVD  = 2'd3
  } reqOp_e;

  localparam logic [11:0] FAULT_NONE = 12'h000;
  localparam logic [11:0] FAULT_BUS  = 12'h008;
  localparam logic [11:0] FAULT_ECC  = 12'hC09;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic take;
    logic rdIssue;
    logic capture;
    logic wrIssue;
    logic useMerge;
    logic beatAdv;
    logic finish;
  } ctlStb_t;

  // codeword position of data bit i (powers of two left out)
  function automatic int unsigned codePos(input int unsigned i);
    if (i == 0)       return 3;
    else if (i < 4)   return i + 4;
    else if (i < 11)  return i + 5;
    else if (i < 26)  return i + 6;
    else if (i < 57)  return i + 7;
    else              return i + 8;
  endfunction

  function automatic logic [7:0] secdedCheck(input logic [63:0] d);
    logic [7:0] c;
    int unsigned p;
    c = '0;
    for (int i = 0; i < 64; i++) begin
      p = codePos(i);
      for (int k = 0; k < 7; k++)
        if (p[k]) c[k] = c[k] ^ d[i];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

endpackage

// File: rtl/tcm_merge_dp.sv
module tcm_merge_dp
  import tcm_merge_pkg::*;
#(
  parameter int AW       = 16,
  parameter int MAX_REGS = 4,
  localparam int WAW   = AW - 3,
  localparam int NBEAT = MAX_REGS / 2 + 1,
  localparam int BUFW  = 64 * NBEAT,
  localparam int BIW   = $clog2(NBEAT + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStb_t               stb,
  input  logic [1:0]            reqOp,
  input  logic [WAW-1:0]        reqWord,
  input  logic [7:0]            reqStrb,
  input  logic [MAX_REGS*32-1:0] reqData,
  input  logic [63:0]           memRdata,
  input  logic [7:0]            memRcheck,
  input  logic                  memErr,
  input  logic                  eccEn,
  input  logic                  extErrEn,
  output logic [WAW-1:0]        memAddr,
  output logic [63:0]           memWdata,
  output logic [63:0]           doneData,
  output logic                  doneAbort,
  output logic [11:0]           doneFault,
  output logic                  abortNow
);

  logic [1:0]     opQ;
  logic [WAW-1:0] addrQ;
  logic [7:0]     strbQ;
  logic [BUFW-1:0] bufQ;
  logic [BIW-1:0] beatQ;
  logic [63:0]    mergeQ, rdQ;
  logic           abortQ;
  logic [11:0]    faultQ;

  logic [63:0] beatWord, newWord, mergedWord;
  logic [7:0]  newStrb;
  logic        eccBad, busBad;
  logic [11:0] faultNow;

  assign beatWord = bufQ[int'(beatQ)*64 +: 64];

  always_comb begin
    if (reqOp_e'(opQ) == OP_STM) begin
      newWord = {32'h0, beatWord[31:0]};
      newStrb = 8'h0F;
    end else begin
      newWord = beatWord;
      newStrb = strbQ;
    end
  end

  for (genvar b = 0; b < 8; b++) begin : g_byte
    assign mergedWord[8*b +: 8] = newStrb[b] ? newWord[8*b +: 8] : memRdata[8*b +: 8];
  end

  always_comb begin
    eccBad   = eccEn && (secdedCheck(memRdata) != memRcheck);
    busBad   = extErrEn && memErr;
    abortNow = eccBad || busBad;
    if (eccBad)      faultNow = FAULT_ECC;
    else if (busBad) faultNow = FAULT_BUS;
    else             faultNow = FAULT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= '0;
      addrQ  <= '0;
      strbQ  <= '0;
      bufQ   <= '0;
      beatQ  <= '0;
      mergeQ <= '0;
      rdQ    <= '0;
      abortQ <= 1'b0;
      faultQ <= FAULT_NONE;
    end else begin
      if (stb.take) begin
        opQ    <= reqOp;
        addrQ  <= reqWord;
        strbQ  <= reqStrb;
        bufQ   <= BUFW'(reqData);
        beatQ  <= '0;
        abortQ <= 1'b0;
        faultQ <= FAULT_NONE;
      end
      if (stb.beatAdv) begin
        addrQ <= addrQ + 1'b1;
        beatQ <= beatQ + 1'b1;
      end
      if (stb.capture) begin
        mergeQ <= mergedWord;
        rdQ    <= memRdata;
        abortQ <= abortNow;
        faultQ <= faultNow;
      end
    end
  end

  assign memAddr   = addrQ;
  assign memWdata  = stb.useMerge ? mergeQ : beatWord;
  assign doneData  = rdQ;
  assign doneAbort = abortQ;
  assign doneFault = faultQ;

endmodule

// File: rtl/tcm_merge_ctl.sv
module tcm_merge_ctl
  import tcm_merge_pkg::*;
#(
  parameter int MAX_REGS = 4,
  localparam int CW = $clog2(MAX_REGS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic [7:0]    reqStrb,
  input  logic [CW-1:0] reqCount,
  input  logic          abortNow,
  output logic          reqReady,
  output logic          memReq,
  output logic          memWe,
  output logic          doneValid,
  output ctlStb_t       stb
);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_WR, S_FIN} state_e;

  state_e        state, nextState;
  logic [CW-1:0] pairsLeft;
  logic          tailQ, mergeQ, loadQ;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: if (reqValid) begin
        stb.take = 1'b1;
        unique case (reqOp_e'(reqOp))
          OP_STORE: nextState = (reqStrb == 8'hFF) ? S_WR : S_RD;
          OP_STM:   nextState = (reqCount >= CW'(2)) ? S_WR :
                                (reqCount == CW'(1)) ? S_RD : S_FIN;
          default:  nextState = S_RD;
        endcase
      end
      S_RD: begin
        stb.rdIssue = 1'b1;
        nextState   = S_CHK;
      end
      S_CHK: begin
        stb.capture = 1'b1;
        nextState   = (loadQ || abortNow) ? S_FIN : S_WR;
      end
      S_WR: begin
        stb.wrIssue  = 1'b1;
        stb.useMerge = mergeQ;
        stb.beatAdv  = !mergeQ;
        if (mergeQ)                   nextState = S_FIN;
        else if (pairsLeft > CW'(1))  nextState = S_WR;
        else if (tailQ)               nextState = S_RD;
        else                          nextState = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      pairsLeft <= '0;
      tailQ     <= 1'b0;
      mergeQ    <= 1'b0;
      loadQ     <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.take) begin
        loadQ     <= (reqOp_e'(reqOp) != OP_STORE) && (reqOp_e'(reqOp) != OP_STM);
        pairsLeft <= (reqOp_e'(reqOp) == OP_STM) ? (reqCount >> 1) : '0;
        tailQ     <= (reqOp_e'(reqOp) == OP_STM) && reqCount[0];
        mergeQ    <= 1'b0;
      end
      if (stb.capture) mergeQ <= 1'b1;
      if (stb.wrIssue && !mergeQ && pairsLeft != '0) pairsLeft <= pairsLeft - 1'b1;
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign memReq    = stb.rdIssue || stb.wrIssue;
  assign memWe     = stb.wrIssue;
  assign doneValid = stb.finish;

endmodule

// File: rtl/tcm_merge_ctrl.sv
module tcm_merge_ctrl
  import tcm_merge_pkg::*;
#(
  parameter int AW       = 16,
  parameter int MAX_REGS = 4,
  localparam int CW = $clog2(MAX_REGS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqOp,
  input  logic [AW-1:0]          reqAddr,
  input  logic [7:0]             reqStrb,
  input  logic [CW-1:0]          reqCount,
  input  logic [MAX_REGS*32-1:0] reqData,
  input  logic                   rmwEn,
  input  logic                   eccEn,
  input  logic                   extErrEn,
  output logic                   memReq,
  output logic                   memWe,
  output logic [AW-4:0]          memAddr,
  output logic [63:0]            memWdata,
  input  logic [63:0]            memRdata,
  input  logic [7:0]             memRcheck,
  input  logic                   memErr,
  output logic                   doneValid,
  output logic [63:0]            doneData,
  output logic                   doneAbort,
  output logic [11:0]            doneFault
);

  ctlStb_t ctlStb;
  logic    abortNow;
  logic    unusedBits;

  // narrow stores always merge, so the optional control bit is not consulted
  assign unusedBits = ^{rmwEn, reqAddr[2:0]};

  tcm_merge_ctl #(.MAX_REGS(MAX_REGS)) i_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqStrb  (reqStrb),
    .reqCount (reqCount),
    .abortNow (abortNow),
    .reqReady (reqReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .doneValid(doneValid),
    .stb      (ctlStb)
  );

  tcm_merge_dp #(.AW(AW), .MAX_REGS(MAX_REGS)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctlStb),
    .reqOp    (reqOp),
    .reqWord  (reqAddr[AW-1:3]),
    .reqStrb  (reqStrb),
    .reqData  (reqData),
    .memRdata (memRdata),
    .memRcheck(memRcheck),
    .memErr   (memErr),
    .eccEn    (eccEn),
    .extErrEn (extErrEn),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .doneData (doneData),
    .doneAbort(doneAbort),
    .doneFault(doneFault),
    .abortNow (abortNow)
  );

endmodule

// File: rtl/tcm_merge_chk.sv
module tcm_merge_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memReq,
  input logic        memWe,
  input logic        doneValid,
  input logic        doneAbort,
  input logic [11:0] doneFault,
  input logic        eccEn,
  input logic        extErrEn,
  input logic        capture,
  input logic        abortNow
);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReq && !doneValid));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  a_r2_read_gap: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> !memReq);

  a_r7_disabled_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !$past(eccEn) && !$past(extErrEn)) |-> !doneAbort);

  a_r7_abort_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (capture && abortNow) |=> !memReq);

  a_r8_abort_code: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneAbort) |-> (doneFault == 12'hC09 || doneFault == 12'h008));

  a_r8_clean_code: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !doneAbort) |-> (doneFault == 12'h000));

endmodule

bind tcm_merge_ctrl tcm_merge_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .memReq   (memReq),
  .memWe    (memWe),
  .doneValid(doneValid),
  .doneAbort(doneAbort),
  .doneFault(doneFault),
  .eccEn    (eccEn),
  .extErrEn (extErrEn),
  .capture  (ctlStb.capture),
  .abortNow (abortNow)
);

// File: tb/test_tcm_merge_ctrl.sv
module test_tcm_merge_ctrl;
  localparam int AW = 16, MAX_REGS = 4, CW = 3, IMPL = 12, NW = 16;
  localparam logic [63:0] GARB = 64'hFFFF_0000_1234_0001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, reqReady, rmwEn, eccEn, extErrEn;
  logic [1:0] reqOp;
  logic [AW-1:0] reqAddr;
  logic [7:0] reqStrb;
  logic [CW-1:0] reqCount;
  logic [MAX_REGS*32-1:0] reqData;
  logic memReq, memWe, memErr, doneValid, doneAbort;
  logic [AW-4:0] memAddr;
  logic [63:0] memWdata, memRdata, doneData;
  logic [7:0] memRcheck;
  logic [11:0] doneFault;

  tcm_merge_ctrl #(.AW(AW), .MAX_REGS(MAX_REGS)) i_tcm_merge_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqStrb(reqStrb), .reqCount(reqCount),
    .reqData(reqData), .rmwEn(rmwEn), .eccEn(eccEn), .extErrEn(extErrEn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memRcheck(memRcheck), .memErr(memErr),
    .doneValid(doneValid), .doneData(doneData), .doneAbort(doneAbort),
    .doneFault(doneFault));

  // reference check byte: walk positions, skipping powers of two
  function automatic logic [7:0] refCode(input logic [63:0] d);
    logic [7:0] c = '0;
    int pos = 2;
    for (int i = 0; i < 64; i++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 7; k++)
        if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    end
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  // memory model
  logic [63:0] mem [NW];
  logic [7:0]  chk [NW];
  logic [63:0] rdQ;
  logic [7:0]  rcQ;
  logic        errQ, forceErr;
  assign memRdata  = rdQ;
  assign memRcheck = rcQ;
  assign memErr    = errQ | forceErr;

  always @(posedge clk) begin : memModel
    int w;
    w = int'(memAddr);
    errQ <= memReq && !memWe && (w >= IMPL);
    if (memReq && !memWe) begin
      if (w < IMPL) begin rdQ <= mem[w]; rcQ <= chk[w]; end
      else begin rdQ <= GARB; rcQ <= ~refCode(GARB); end
    end else if (memReq && memWe && w < IMPL) begin
      mem[w] <= memWdata;
      chk[w] <= refCode(memWdata);
    end
  end

  // cycle-by-cycle expectation queue
  typedef struct {
    bit req; bit we; int addr; logic [63:0] wdata;
    bit done; bit abort; logic [11:0] fault; logic [63:0] rdata; bit chkData;
    string tag;
  } exp_t;
  exp_t expQ[$];
  int checks = 0, fails = 0;
  bit started = 0, finished = 0;

  function automatic void cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  function automatic void pushRec(bit req, bit we, int addr, logic [63:0] wd, bit done,
                                  bit ab, logic [11:0] f, logic [63:0] rd, bit cd, string tag);
    exp_t e;
    e.req = req; e.we = we; e.addr = addr; e.wdata = wd; e.done = done;
    e.abort = ab; e.fault = f; e.rdata = rd; e.chkData = cd; e.tag = tag;
    expQ.push_back(e);
  endfunction

  function automatic logic [63:0] oldWord(int w);
    return (w < IMPL) ? mem[w] : GARB;
  endfunction

  function automatic void faultFor(int w, output bit ab, output logic [11:0] f);
    bit bus, ecc;
    bus = (w >= IMPL) && extErrEn;
    ecc = ((w >= IMPL) || (chk[w] != refCode(mem[w]))) && eccEn;
    ab  = bus || ecc;
    f   = ecc ? 12'hC09 : (bus ? 12'h008 : 12'h000);
  endfunction

  function automatic logic [63:0] mergeBytes(logic [63:0] o, logic [63:0] n, logic [7:0] s);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = s[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic void rmwRecs(int w, logic [63:0] nw, logic [7:0] s, string tag);
    bit ab; logic [11:0] f;
    pushRec(1, 0, w, 0, 0, 0, 0, 0, 0, tag);
    pushRec(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    faultFor(w, ab, f);
    if (!ab) pushRec(1, 1, w, mergeBytes(oldWord(w), nw, s), 0, 0, 0, 0, 0, tag);
    pushRec(0, 0, 0, 0, 1, ab, f, 0, 0, tag);
  endfunction

  task automatic doReq(logic [1:0] op, int word, logic [7:0] strb, logic [127:0] data,
                       int cnt, string tag);
    bit ab; logic [11:0] f;
    @(negedge clk);
    reqValid = 1; reqOp = op; reqAddr = AW'(word * 8); reqStrb = strb;
    reqData = data; reqCount = CW'(cnt);
    @(posedge clk); #1;
    reqValid = 0;
    case (op)
      2'd0: begin
        faultFor(word, ab, f);
        pushRec(1, 0, word, 0, 0, 0, 0, 0, 0, tag);
        pushRec(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
        pushRec(0, 0, 0, 0, 1, ab, f, oldWord(word), !ab, tag);
      end
      2'd1: begin
        if (strb == 8'hFF) begin
          pushRec(1, 1, word, data[63:0], 0, 0, 0, 0, 0, tag);
          pushRec(0, 0, 0, 0, 1, 0, 12'h000, 0, 0, tag);
        end else rmwRecs(word, data[63:0], strb, tag);
      end
      default: begin
        for (int k = 0; k < cnt / 2; k++)
          pushRec(1, 1, word + k, data[64*k +: 64], 0, 0, 0, 0, 0, tag);
        if (cnt % 2 == 1)
          rmwRecs(word + cnt / 2, {32'h0, data[32*(cnt-1) +: 32]}, 8'h0F, tag);
        else
          pushRec(0, 0, 0, 0, 1, 0, 12'h000, 0, 0, tag);
      end
    endcase
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // compare outputs against the expectation on every cycle
  always @(negedge clk) begin : monitor
    exp_t e;
    if (started && !finished) begin
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        cmp("R10", "reqReady busy", 64'(reqReady), 64'(0));
        cmp(e.tag, "memReq", 64'(memReq), 64'(e.req));
        if (e.req) begin
          cmp(e.tag, "memWe", 64'(memWe), 64'(e.we));
          cmp(e.tag, "memAddr", 64'(memAddr), 64'(e.addr));
          if (e.we) cmp(e.tag, "memWdata", memWdata, e.wdata);
        end
        cmp(e.tag, "doneValid", 64'(doneValid), 64'(e.done));
        if (e.done) begin
          cmp(e.tag, "doneAbort", 64'(doneAbort), 64'(e.abort));
          cmp(e.tag, "doneFault", 64'(doneFault), 64'(e.fault));
          if (e.chkData) cmp(e.tag, "doneData", doneData, e.rdata);
        end
      end else begin
        cmp("R10", "idle reqReady", 64'(reqReady), 64'(1));
        cmp("R10", "idle memReq", 64'(memReq), 64'(0));
        cmp("R10", "idle doneValid", 64'(doneValid), 64'(0));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 0; reqValid = 0; reqOp = 0; reqAddr = 0; reqStrb = 0; reqCount = 0;
    reqData = 0; rmwEn = 0; eccEn = 1; extErrEn = 1; forceErr = 0;
    rdQ = 0; rcQ = 0; errQ = 0;
    for (int i = 0; i < NW; i++) begin
      mem[i] = {32'(i) * 32'h0101_0101, 32'hA5A5_0000 + 32'(i)};
      chk[i] = refCode(mem[i]);
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    cmp("R10", "reset reqReady", 64'(reqReady), 64'(1));
    cmp("R10", "reset memReq", 64'(memReq), 64'(0));
    cmp("R10", "reset doneValid", 64'(doneValid), 64'(0));
    started = 1;

    doReq(2'd1, 2, 8'hFF, 128'h1111_2222_3333_4444, 0, "R1");
    doReq(2'd0, 2, 8'h00, 0, 0, "R6");
    doReq(2'd1, 3, 8'b1010_0101, 128'hCAFE_BABE_DEAD_BEEF, 0, "R2");
    doReq(2'd0, 3, 8'h00, 0, 0, "R11");
    rmwEn = 1;
    doReq(2'd1, 3, 8'h30, 128'h0000_7766_0000_0000, 0, "R3");
    rmwEn = 0;
    doReq(2'd1, 6, 8'h01, 128'h0000_0000_0000_00EE, 0, "R3");
    doReq(2'd2, 5, 8'h00, {32'hD3D3_D3D3, 32'hC2C2_C2C2, 32'hB1B1_B1B1, 32'hA0A0_A0A0}, 4, "R4");
    doReq(2'd2, 7, 8'h00, {32'h0, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001}, 3, "R5");
    doReq(2'd2, 9, 8'h00, {96'h0, 32'h9999_0009}, 1, "R5");
    doReq(2'd0, 8, 8'h00, 0, 0, "R5");

    eccEn = 0; extErrEn = 1;
    doReq(2'd0, 13, 8'h00, 0, 0, "R7");
    eccEn = 0; extErrEn = 0;
    doReq(2'd0, 13, 8'h00, 0, 0, "R7");
    doReq(2'd1, 14, 8'h0F, 128'h1234, 0, "R7");
    eccEn = 1; extErrEn = 1;
    doReq(2'd0, 13, 8'h00, 0, 0, "R8");
    eccEn = 0; extErrEn = 1;
    doReq(2'd1, 15, 8'h3C, 128'h55, 0, "R8");

    chk[4] = chk[4] ^ 8'h01;
    eccEn = 1; extErrEn = 0;
    doReq(2'd1, 4, 8'hF0, 128'hFFFF_FFFF_0000_0000, 0, "R7");
    doReq(2'd1, 4, 8'hFF, 128'h4444_4444_4444_4444, 0, "R7");
    doReq(2'd0, 4, 8'h00, 0, 0, "R11");

    eccEn = 1; extErrEn = 1;
    doReq(2'd1, 14, 8'hFF, 128'h77, 0, "R1");
    forceErr = 1;
    doReq(2'd1, 1, 8'hFF, 128'h0101_0101_0101_0101, 0, "R9");
    doReq(2'd2, 0, 8'h00, {64'h0, 32'hBBBB_BBBB, 32'hAAAA_AAAA}, 2, "R9");
    forceErr = 0;
    doReq(2'd0, 1, 8'h00, 0, 0, "R9");
    doReq(2'd2, 11, 8'h00, {32'h0, 32'h0C0C_0C0C, 32'h0B0B_0B0B, 32'h0A0A_0A0A}, 3, "R7");
    doReq(2'd0, 11, 8'h00, 0, 0, "R4");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule